// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital controller placed in front of an analog-to-digital conversion core. Software programs one 8-bit control register. The register selects a channel, one of four operating modes, a run/halt control and a conversion clock rate. From these settings the sequencer decides which of the five analog inputs to convert and in what order. It sends each request to the conversion core as a one-cycle start pulse carrying a channel number. It then waits for the core's done pulse and places the returned 10-bit value in a result register kept for that channel.

While a conversion run is active, the register is locked. The only write that takes effect during a run is one that clears the run bit. A cleared run bit is honoured once the conversion already in flight has returned its result. The block also divides the system clock into a conversion clock enable, and the rate of that enable is picked by a register bit. A result port with its own channel selector makes every stored result readable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control register reads back as {bit7 rate select, bit6 run, bit5 constant 0, bits4:3 mode, bits2:0 channel}. Mode codes: 00 one conversion, 01 continuous on one channel, 10 one pass over all channels, 11 continuous passes. Writing 1 to bit5 has no effect on the read value.
- R2: After reset the register reads 0x00, every result reads 0, `busy` is 0 and no start pulse is issued.
- R3: While `busy` is 1, a write with bit6 = 1 changes nothing. A write with bit6 = 0 clears only the run bit and leaves the other fields as they were.
- R4: With mode 00 or 01, a write from the halted state that sets bit6 while the channel field is 5, 6 or 7 loads the other fields, leaves the run bit at 0 and starts no conversion.
- R5: Mode 00 converts the selected channel once, stores the result and then clears the run bit by itself.
- R6: Mode 01 converts the selected channel over and over until software clears the run bit.
- R7: Mode 10 converts channels 0,1,2,3,4 in that order once, ignores the channel field and then clears the run bit by itself.
- R8: Mode 11 converts channels 0 to 4 in ascending order and wraps from 4 back to 0 until the run bit is cleared.
- R9: `core_start` is high for exactly one cycle, only in a cycle where `conv_clk_en` is high, and only with a channel number below 5. No new start is issued before the previous request's `core_done`.
- R10: Each `core_done` writes `core_result` into the result register of the channel that was requested. `res_data` shows the register picked by `res_sel`, and reads 0 for selector values 5 to 7.
- R11: With bit7 = 0, `conv_clk_en` is high once every 4 clocks. With bit7 = 1, it is high once every 2 clocks.
- R12: After the run bit is cleared, a conversion that was already started completes and its result is stored. `busy` then falls, and no further start pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| busy | output | 1 | Run bit set or conversion outstanding |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| core_start | output | 1 | One-cycle conversion request to the core |
| core_chan | output | 3 | Channel number of the request |
| core_done | input | 1 | Conversion complete pulse from the core |
| core_result | input | 10 | Converted value, valid with core_done |
| res_sel | input | 3 | Result register selector |
| res_data | output | 10 | Selected result register |

## Verification
The bench builds the block with its defaults: five channels, 10-bit results, and clock dividers of 4 and 2. With five channels, selector codes 5 to 7 exist, so both the rejected-start path and the zero read-back of unused result slots can be exercised. The two dividers give enable periods that a 40-cycle count distinguishes. Because the channel count is below the field range, the wrap from channel 4 to 0 in continuous passes is reached after five conversions. A halt that arrives mid-conversion is observable against a stub core with a three-cycle latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // operating mode codes held in control bits 4:3
   typedef enum logic [1:0] {
      MODE_ONCE       = 2'b00,
      MODE_LOOP       = 2'b01,
      MODE_PASS       = 2'b10,
      MODE_PASS_LOOP  = 2'b11
   } adc_mode_e;

   // sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ARM  = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_e;

   localparam int unsigned CHAN_W    = 3;
   localparam int unsigned CHAN_LSB  = 0;
   localparam int unsigned MODE_LSB  = 3;
   localparam int unsigned RSVD_BIT  = 5;
   localparam int unsigned RUN_BIT   = 6;
   localparam int unsigned RATE_BIT  = 7;

   typedef struct packed {
      logic                rate;
      logic                run;
      adc_mode_e           mode;
      logic [CHAN_W-1:0]   chan;
   } adc_ctrl_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        seq_active,
   input  logic        self_clear,
   output adc_ctrl_t   ctrl,
   output logic [7:0]  rd_data,
   output logic        halted
);

   localparam logic [CHAN_W-1:0] LAST_CH = CHAN_W'(NUM_CH - 1);

   logic chan_legal;
   logic unused_rsvd;

   assign halted      = !ctrl.run && !seq_active;
   // sweep modes ignore the channel field; the single-channel modes need a real one
   assign chan_legal  = wr_data[MODE_LSB+1] ||
                        (wr_data[CHAN_LSB +: CHAN_W] <= LAST_CH);
   assign unused_rsvd = wr_data[RSVD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_en && halted) begin
            ctrl.chan <= wr_data[CHAN_LSB +: CHAN_W];
            ctrl.mode <= adc_mode_e'(wr_data[MODE_LSB +: 2]);
            ctrl.rate <= wr_data[RATE_BIT];
            ctrl.run  <= wr_data[RUN_BIT] && chan_legal;
         end else if (wr_en && !wr_data[RUN_BIT]) begin
            ctrl.run  <= 1'b0;
         end
         if (self_clear) begin
            ctrl.run <= 1'b0;
         end
      end
   end

   assign rd_data = {ctrl.rate, ctrl.run, 1'b0, ctrl.mode, ctrl.chan};

endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
   parameter int unsigned DIV_SLOW = 4,
   parameter int unsigned DIV_FAST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast,
   output logic tick
);

   localparam int unsigned DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int unsigned CW   = (DMAX > 1) ? $clog2(DMAX) : 1;
   localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
   localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = fast ? LIM_FAST : LIM_SLOW;
   // >= keeps the period bounded right after a rate change
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  adc_mode_e          mode,
   input  logic [CHAN_W-1:0]  chan,
   input  logic               tick,
   input  logic               core_done,
   output logic               core_start,
   output logic [CHAN_W-1:0]  core_chan,
   output logic               seq_active,
   output logic               self_clear,
   output logic               res_we,
   output logic [CHAN_W-1:0]  res_ch
);

   localparam logic [CHAN_W-1:0] LAST_CH = CHAN_W'(NUM_CH - 1);

   seq_state_e          state;
   logic [CHAN_W-1:0]   cur;
   logic                sweep;
   logic                looping;
   logic                final_conv;
   logic                done_here;

   assign sweep      = mode[1];
   assign looping    = mode[0];
   assign final_conv = !looping && (!sweep || (cur == LAST_CH));
   assign done_here  = (state == SQ_WAIT) && core_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cur   <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (run) begin
                  state <= SQ_ARM;
                  cur   <= sweep ? '0 : chan;
               end
            end
            SQ_ARM: begin
               if (!run) begin
                  state <= SQ_IDLE;
               end else if (tick) begin
                  state <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (core_done) begin
                  state <= (!run || final_conv) ? SQ_IDLE : SQ_ARM;
                  if (sweep) begin
                     cur <= (cur == LAST_CH) ? '0 : cur + 1'b1;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign core_start = (state == SQ_ARM) && tick && run;
   assign core_chan  = cur;
   assign seq_active = (state != SQ_IDLE);
   assign self_clear = done_here && run && final_conv;
   assign res_we     = done_here;
   assign res_ch     = cur;

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned RES_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [CHAN_W-1:0]  wch,
   input  logic [RES_W-1:0]   wdata,
   input  logic [CHAN_W-1:0]  rsel,
   output logic [RES_W-1:0]   rdata
);

   localparam logic [CHAN_W-1:0] LAST_CH = CHAN_W'(NUM_CH - 1);

   logic [NUM_CH*RES_W-1:0] flat;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      logic [RES_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (wch == CHAN_W'(i))) begin
            q <= wdata;
         end
      end
      assign flat[i*RES_W +: RES_W] = q;
   end

   always_comb begin
      rdata = '0;
      if (rsel <= LAST_CH) begin
         rdata = flat[rsel*RES_W +: RES_W];
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 5,
   parameter int unsigned RES_W    = 10,
   parameter int unsigned DIV_SLOW = 4,
   parameter int unsigned DIV_FAST = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   output logic        busy,
   output logic        conv_clk_en,
   output logic        core_start,
   output logic [2:0]  core_chan,
   input  logic        core_done,
   input  logic [9:0]  core_result,
   input  logic [2:0]  res_sel,
   output logic [9:0]  res_data
);

   if (NUM_CH < 1 || NUM_CH > (1 << CHAN_W)) begin : g_bad_num_ch
      $error("adc_seq_ctrl: NUM_CH must lie in 1..8");
   end
   if (RES_W != 10) begin : g_bad_res_w
      $error("adc_seq_ctrl: RES_W must match the 10-bit result ports");
   end
   if (DIV_SLOW < 1 || DIV_FAST < 1) begin : g_bad_div
      $error("adc_seq_ctrl: clock dividers must be at least 1");
   end

   adc_ctrl_t          ctrl;
   logic               halted;
   logic               seq_active;
   logic               self_clear;
   logic               res_we;
   logic [CHAN_W-1:0]  res_ch;

   adc_seq_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .seq_active (seq_active),
      .self_clear (self_clear),
      .ctrl       (ctrl),
      .rd_data    (rd_data),
      .halted     (halted)
   );

   adc_seq_clkdiv #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_clkdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .fast  (ctrl.rate),
      .tick  (conv_clk_en)
   );

   adc_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl.run),
      .mode       (ctrl.mode),
      .chan       (ctrl.chan),
      .tick       (conv_clk_en),
      .core_done  (core_done),
      .core_start (core_start),
      .core_chan  (core_chan),
      .seq_active (seq_active),
      .self_clear (self_clear),
      .res_we     (res_we),
      .res_ch     (res_ch)
   );

   adc_seq_results #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_results (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (res_we),
      .wch   (res_ch),
      .wdata (core_result),
      .rsel  (res_sel),
      .rdata (res_data)
   );

   assign busy = !halted;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int unsigned NUM_CH = 5
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [7:0]  wr_data,
   input logic [7:0]  rd_data,
   input logic        busy,
   input logic        conv_clk_en,
   input logic        core_start,
   input logic [2:0]  core_chan
);

   localparam logic [2:0] LAST_CH = 3'(NUM_CH - 1);

   logic unused_bits;
   assign unused_bits = ^{wr_data[7], wr_data[5], wr_data[3], rd_data[5]};

   // R9: requests only on an enable cycle
   a_r9_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> conv_clk_en);

   // R9: request is a single-cycle pulse
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   // R4: never a request on a missing channel
   a_r4_legal_chan: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> (core_chan <= LAST_CH));

   // R3: locked fields hold during a run
   a_r3_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && wr_data[6]) |=> $stable({rd_data[7], rd_data[4:0]}));

   // R3: clearing the run bit always lands
   a_r3_clear_run: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[6]) |=> !rd_data[6]);

   // R4: start with a reserved channel is refused
   a_r4_reject_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && wr_data[6] && !wr_data[4] && (wr_data[2:0] > LAST_CH))
      |=> !rd_data[6]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .busy        (busy),
   .conv_clk_en (conv_clk_en),
   .core_start  (core_start),
   .core_chan   (core_chan)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

   localparam int STUB_LAT = 3;
   // {control byte, expected conversion count}
   localparam logic [11:0] VEC_TAB [7] = '{
      12'h401, 12'hC31, 12'h441, 12'h575, 12'hD25, 12'h460, 12'h4D0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       busy;
   logic       conv_clk_en;
   logic       core_start;
   logic [2:0] core_chan;
   logic       core_done;
   logic [9:0] core_result;
   logic [2:0] res_sel = '0;
   logic [9:0] res_data;

   int n_vec = 0;
   int n_bad = 0;

   // stub conversion core state
   int         log_n = 0;
   int         done_n = 0;
   int         serial = 0;
   int         viol = 0;
   int         log_ch [0:511];
   logic [9:0] last_res [0:7];
   logic       st_busy;
   int         st_cnt;
   logic [2:0] st_ch;

   always #4 clk = ~clk;

   adc_seq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .busy        (busy),
      .conv_clk_en (conv_clk_en),
      .core_start  (core_start),
      .core_chan   (core_chan),
      .core_done   (core_done),
      .core_result (core_result),
      .res_sel     (res_sel),
      .res_data    (res_data)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         core_done   <= 1'b0;
         core_result <= '0;
         st_busy     <= 1'b0;
         st_cnt      <= 0;
         st_ch       <= '0;
         for (int i = 0; i < 8; i++) last_res[i] <= '0;
      end else begin
         core_done <= 1'b0;
         if (core_start) begin
            if (!conv_clk_en || st_busy || core_chan > 3'd4) viol <= viol + 1;
            if (log_n < 512) log_ch[log_n] <= int'(core_chan);
            log_n   <= log_n + 1;
            st_ch   <= core_chan;
            st_cnt  <= STUB_LAT;
            st_busy <= 1'b1;
         end else if (st_busy) begin
            if (st_cnt == 1) begin
               core_done   <= 1'b1;
               core_result <= 10'((int'(st_ch) * 97 + serial * 13) & 1023);
               last_res[st_ch] <= 10'((int'(st_ch) * 97 + serial * 13) & 1023);
               serial  <= serial + 1;
               done_n  <= done_n + 1;
               st_busy <= 1'b0;
            end else begin
               st_cnt <= st_cnt - 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int k;
      k = 0;
      while (busy && k < 3000) begin
         @(negedge clk);
         k++;
      end
      check(!busy, req, int'(busy), 0);
   endtask

   task automatic wait_count(input int target, input string req);
      int k;
      k = 0;
      while (log_n < target && k < 3000) begin
         @(negedge clk);
         k++;
      end
      check(log_n >= target, req, log_n, target);
   endtask

   task automatic check_result(input logic [2:0] ch, input string req);
      res_sel = ch;
      #1;
      check(res_data == last_res[ch], req, int'(res_data), int'(last_res[ch]));
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      int n_at;
      int cnt;
      repeat (3) @(negedge clk);
      // R2: reset state
      check(rd_data == 8'h00, "R2 control reset", int'(rd_data), 0);
      check(!busy && !core_start, "R2 idle at reset", int'({busy, core_start}), 0);
      check(res_data == 10'd0, "R2 result reset", int'(res_data), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(rd_data == 8'h00, "R2 control after release", int'(rd_data), 0);

      // vector table: finite runs and refused starts (R4 R5 R7 R10)
      for (int v = 0; v < 7; v++) begin
         logic [7:0] c;
         int n_exp;
         c     = VEC_TAB[v][11:4];
         n_exp = int'(VEC_TAB[v][3:0]);
         base  = log_n;
         wr(c);
         wait_idle("R5 R7 run ends");
         repeat (2) @(negedge clk);
         check(log_n - base == n_exp, "R5 R7 R4 conversion count", log_n - base, n_exp);
         check(rd_data == (c & 8'hBF), "R5 R7 R4 run bit self cleared", int'(rd_data), int'(c & 8'hBF));
         for (int k = 0; k < n_exp; k++) begin
            int e;
            e = c[4] ? k : int'(c[2:0]);
            check(log_ch[base + k] == e, "R5 R7 channel order", log_ch[base + k], e);
            check_result(3'(e), "R10 stored result");
         end
      end

      // R6 R3 R12: continuous single channel, lock, then halt
      base = log_n;
      wr(8'h4A);
      wait_count(base + 3, "R6 keeps converting");
      check(busy && rd_data == 8'h4A, "R6 still running", int'(rd_data), 8'h4A);
      wr(8'h5F);
      check(rd_data == 8'h4A, "R3 write ignored while busy", int'(rd_data), 8'h4A);
      wr(8'h80);
      check(rd_data == 8'h0A, "R3 clear touches only run bit", int'(rd_data), 8'h0A);
      n_at = log_n;
      wait_idle("R12 busy falls after halt");
      @(negedge clk);
      check(log_n - n_at <= 1, "R12 at most one start after halt", log_n - n_at, 1);
      check(done_n == log_n, "R12 in-flight conversion completes", done_n, log_n);
      for (int k = base; k < log_n; k++)
         check(log_ch[k] == 2, "R6 only selected channel", log_ch[k], 2);
      check_result(3'd2, "R12 R10 last result stored");
      n_at = log_n;
      repeat (20) @(negedge clk);
      check(log_n == n_at, "R12 no start after idle", log_n, n_at);

      // R8: continuous passes with wrap
      base = log_n;
      wr(8'hD8);
      wait_count(base + 7, "R8 keeps sweeping");
      wr(8'h00);
      wait_idle("R8 halt");
      for (int k = 0; k < 7; k++)
         check(log_ch[base + k] == k % 5, "R8 wrap order", log_ch[base + k], k % 5);
      check(rd_data == 8'h98, "R8 fields kept after halt", int'(rd_data), 8'h98);

      // R1: halted write loads all fields, bit5 reads 0
      wr(8'hBB);
      check(rd_data == 8'h9B, "R1 layout and bit5 zero", int'(rd_data), 8'h9B);

      // R11: enable rates
      wr(8'h00);
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (conv_clk_en) cnt++;
      end
      check(cnt == 10, "R11 slow enable rate", cnt, 10);
      wr(8'h80);
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (conv_clk_en) cnt++;
      end
      check(cnt == 20, "R11 fast enable rate", cnt, 20);

      // R10: unused selector reads zero
      res_sel = 3'd7;
      #1;
      check(res_data == 10'd0, "R10 out-of-range selector", int'(res_data), 0);

      // R9: stub saw only legal requests
      check(viol == 0, "R9 request protocol", viol, 0);
      finish_run();
   end

endmodule